// File: doc/BRIEF.md
# Nested Interrupt Level Arbiter

This block decides at which instruction boundary a processor core may take a hardware interrupt, and which one. Each request line carries a 3-bit level and a flag that marks it as a transfer request for an I/O service channel rather than a normal handler. The core supplies its current level mask, a global enable, a strobe for every completed instruction, and two qualifiers for that instruction: it touched the internal I/O area, or it was an interrupt-inhibit instruction.

On acceptance the block pulses a strobe for one cycle. With the strobe it gives the winning request index, the level the core must load into its mask, and whether the winner starts a service transfer. Nesting follows from the mask. A handler runs with the mask at its own level, so only strictly higher-priority (numerically lower) requests can break in. When the core restores the old mask, the interrupted handler carries on.

A service transfer holds off every acceptance until the channel reports it is finished. Request flags belong to the peripherals and are never cleared here. A flag that stays set is taken again as soon as the mask allows it.

Top module: `irq_level_arbiter`

## Requirements
- R1: A request is eligible only when its valid bit is 1, `int_enable` is 1 and its level is numerically below `cur_mask`. Level 7 is therefore never taken.
- R2: Among eligible requests the lowest level value wins. Between equal levels, the lowest request index wins.
- R3: A decision is made only in a cycle with `instr_done` high. The accept outputs are registered and appear in the following cycle as a one-cycle `acc_valid` pulse. When `acc_valid` is 0, `acc_index`, `acc_level` and `acc_svc` read 0.
- R4: While a handler runs with the mask at its level L, a request at a level below L is accepted at the next allowed boundary. A request at level L or above stays pending until software raises the mask.
- R5: With `int_enable` at 0, nothing is accepted whatever the requests and the mask.
- R6: A boundary whose instruction had `instr_io_access` high accepts nothing, and neither does the next boundary. Acceptance is possible again from the boundary after that.
- R7: The same deferral as in R6 applies when `instr_inhibit` is high at a boundary.
- R8: After a service acceptance, no acceptance of any kind happens until `svc_done` is seen. A boundary in the same cycle as `svc_done` is still blocked.
- R9: Acceptance does not consume a request. A request still asserted is accepted again once the mask is raised above its level.
- R10: After reset, `acc_valid` is 0, no deferral is pending and no service transfer is active.
- R11: An accepted request whose bit in `req_svc` is 1 reports `acc_svc` = 1 with its index and level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NUM_REQ | Request flags from the peripherals |
| req_level | input | NUM_REQ*3 | Level of request i in bits [3i+2:3i] |
| req_svc | input | NUM_REQ | Request i starts a service transfer instead of a handler |
| cur_mask | input | 3 | Current level mask held by the core |
| int_enable | input | 1 | Global interrupt enable |
| instr_done | input | 1 | Instruction boundary strobe |
| instr_io_access | input | 1 | Completed instruction accessed internal I/O |
| instr_inhibit | input | 1 | Completed instruction is an interrupt-inhibit instruction |
| svc_done | input | 1 | Service channel reports end of transfer |
| acc_valid | output | 1 | One-cycle accept strobe |
| acc_index | output | $clog2(NUM_REQ) | Winning request index |
| acc_level | output | 3 | Winning level, the new mask value |
| acc_svc | output | 1 | Winner starts a service transfer |

## Verification
Two pairs of events can share a cycle. In the first, a boundary carries a deferral qualifier while a higher-priority request is pending. In the second, `svc_done` coincides with a boundary while another request is waiting. The bench drives both coincidences on purpose. It expects the qualifier to win and the boundary to stay empty, and it expects the end-of-service cycle to stay blocked, so the waiting request is accepted only at the following boundary. A behavioural model steps with the design every clock and judges all four accept outputs in each cycle, not only at the directed checkpoints.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  parameter int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  // eligibility: enabled and strictly more urgent than the mask
  function automatic logic is_eligible(input logic en, input lvl_t lvl, input lvl_t mask);
    return en && (lvl < mask);
  endfunction

  // strict compare keeps the earlier (lower) index on ties
  function automatic logic beats(input lvl_t cand, input lvl_t best);
    return cand < best;
  endfunction
endpackage

// File: rtl/irqarb_pick.sv
module irqarb_pick
  import irqarb_pkg::*;
#(
  parameter int NUM_REQ = 8,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0]       req_valid,
  input  logic [NUM_REQ*LVL_W-1:0] req_level,
  input  lvl_t                     mask,
  input  logic                     en,
  output logic                     found,
  output logic [IDX_W-1:0]         win_idx,
  output lvl_t                     win_lvl
);
  lvl_t lvls [NUM_REQ];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_slice
    assign lvls[g] = req_level[g*LVL_W +: LVL_W];
  end

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '1;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req_valid[i] && is_eligible(en, lvls[i], mask) &&
          (!found || beats(lvls[i], win_lvl))) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvls[i];
      end
    end
  end
endmodule

// File: rtl/irqarb_defer.sv
module irqarb_defer (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic hold_flag,
  output logic defer_q
);
  // set by a flagged boundary, cleared by the next boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        defer_q <= 1'b0;
    else if (boundary) defer_q <= hold_flag;
  end
endmodule

// File: rtl/irqarb_svc.sv
module irqarb_svc (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic active_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     active_q <= 1'b0;
    else if (start) active_q <= 1'b1;
    else if (done)  active_q <= 1'b0;
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irqarb_pkg::*;
#(
  parameter int NUM_REQ = 8,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REQ-1:0]       req_valid,
  input  logic [NUM_REQ*LVL_W-1:0] req_level,
  input  logic [NUM_REQ-1:0]       req_svc,
  input  logic [LVL_W-1:0]         cur_mask,
  input  logic                     int_enable,
  input  logic                     instr_done,
  input  logic                     instr_io_access,
  input  logic                     instr_inhibit,
  input  logic                     svc_done,
  output logic                     acc_valid,
  output logic [IDX_W-1:0]         acc_index,
  output logic [LVL_W-1:0]         acc_level,
  output logic                     acc_svc
);
  logic             win_found;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl;
  logic             defer_q;
  logic             svc_active;
  logic             hold_flag;
  logic             boundary_open;
  logic             take;
  logic             take_svc;

  irqarb_pick #(.NUM_REQ(NUM_REQ)) u_pick (
    .req_valid (req_valid),
    .req_level (req_level),
    .mask      (cur_mask),
    .en        (int_enable),
    .found     (win_found),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  assign hold_flag = instr_io_access | instr_inhibit;

  irqarb_defer u_defer (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (instr_done),
    .hold_flag (hold_flag),
    .defer_q   (defer_q)
  );

  // named decision events
  assign boundary_open = instr_done & ~defer_q & ~svc_active & ~hold_flag;
  assign take          = boundary_open & win_found;
  assign take_svc      = take & req_svc[win_idx];

  irqarb_svc u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (take_svc),
    .done     (svc_done),
    .active_q (svc_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_index <= '0;
      acc_level <= '0;
      acc_svc   <= 1'b0;
    end else begin
      acc_valid <= take;
      acc_index <= take ? win_idx : '0;
      acc_level <= take ? win_lvl : '0;
      acc_svc   <= take_svc;
    end
  end
endmodule

// File: rtl/irqarb_checker.sv
module irqarb_checker
  import irqarb_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] cur_mask,
  input logic             int_enable,
  input logic             instr_done,
  input logic             instr_io_access,
  input logic             instr_inhibit,
  input logic             defer_q,
  input logic             svc_active,
  input logic             acc_valid,
  input logic [IDX_W-1:0] acc_index,
  input logic [LVL_W-1:0] acc_level,
  input logic             acc_svc
);
  a_r3_only_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(instr_done));

  a_r3_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (acc_index == '0 && acc_level == '0 && !acc_svc));

  a_r1_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_level < $past(cur_mask)));

  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(int_enable));

  a_r6_flagged_boundary_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && (instr_io_access || instr_inhibit)) |=> !acc_valid);

  a_r7_pending_defer_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && defer_q) |=> !acc_valid);

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    svc_active |=> !acc_valid);

  a_r11_svc_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_svc) |-> svc_active);
endmodule

bind irq_level_arbiter irqarb_checker #(.IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cur_mask        (cur_mask),
  .int_enable      (int_enable),
  .instr_done      (instr_done),
  .instr_io_access (instr_io_access),
  .instr_inhibit   (instr_inhibit),
  .defer_q         (defer_q),
  .svc_active      (svc_active),
  .acc_valid       (acc_valid),
  .acc_index       (acc_index),
  .acc_level       (acc_level),
  .acc_svc         (acc_svc)
);

// File: tb/test_irq_level_arbiter.sv
`timescale 1ns/1ps
module test_irq_level_arbiter;
  localparam int N  = 8;
  localparam int LW = 3;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_valid = '0;
  logic [N*LW-1:0] req_level = '0;
  logic [N-1:0]  req_svc = '0;
  logic [LW-1:0] cur_mask = 3'd7;
  logic          int_enable = 1'b1;
  logic          instr_done = 1'b0;
  logic          instr_io_access = 1'b0;
  logic          instr_inhibit = 1'b0;
  logic          svc_done = 1'b0;
  logic          acc_valid;
  logic [IW-1:0] acc_index;
  logic [LW-1:0] acc_level;
  logic          acc_svc;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string tag = "R10";

  always #4 clk = ~clk;

  irq_level_arbiter #(.NUM_REQ(N)) i_irq_level_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .req_svc(req_svc), .cur_mask(cur_mask), .int_enable(int_enable),
    .instr_done(instr_done), .instr_io_access(instr_io_access),
    .instr_inhibit(instr_inhibit), .svc_done(svc_done),
    .acc_valid(acc_valid), .acc_index(acc_index), .acc_level(acc_level),
    .acc_svc(acc_svc)
  );

  // behavioural reference
  int m_defer = 0, m_busy = 0;
  int e_v = 0, e_idx = 0, e_lvl = 0, e_svc = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_defer = 0; m_busy = 0; e_v = 0; e_idx = 0; e_lvl = 0; e_svc = 0;
    end else begin
      int best, bidx, lv;
      bit ok;
      best = 99; bidx = -1;
      for (int i = 0; i < N; i++) begin
        lv = int'(req_level[i*LW +: LW]);
        if (req_valid[i] && int_enable && lv < int'(cur_mask) && lv < best) begin
          best = lv; bidx = i;
        end
      end
      ok = instr_done && m_defer == 0 && m_busy == 0 &&
           !instr_io_access && !instr_inhibit && bidx >= 0;
      e_v = ok; e_idx = ok ? bidx : 0; e_lvl = ok ? best : 0;
      e_svc = ok ? int'(req_svc[bidx]) : 0;
      if (instr_done) m_defer = (instr_io_access || instr_inhibit) ? 1 : 0;
      if (ok && e_svc == 1) m_busy = 1;
      else if (svc_done) m_busy = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(tag, int'(acc_valid), e_v, "model acc_valid");
    chk(tag, int'(acc_index), e_idx, "model acc_index");
    chk(tag, int'(acc_level), e_lvl, "model acc_level");
    chk(tag, int'(acc_svc), e_svc, "model acc_svc");
  endtask

  task automatic bnd(input bit io, input bit inh);
    instr_done = 1; instr_io_access = io; instr_inhibit = inh;
    tick();
    instr_done = 0; instr_io_access = 0; instr_inhibit = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic setr(input int i, input bit v, input int lvl, input bit svc);
    req_valid[i] = v;
    req_level[i*LW +: LW] = LW'(lvl);
    req_svc[i] = svc;
  endtask

  task automatic expect_acc(input string req, input int v, input int idx, input int lvl);
    chk(req, int'(acc_valid), v, "acc_valid");
    if (v == 1) begin
      chk(req, int'(acc_index), idx, "acc_index");
      chk(req, int'(acc_level), lvl, "acc_level");
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R10", int'(acc_valid), 0, "acc_valid in reset");
    rst_n = 1;
    idle(2);
    chk("R10", int'(acc_valid), 0, "acc_valid after reset");

    tag = "R1"; // level equal to mask is not taken, below is
    setr(0, 1, 3, 0); cur_mask = 3;
    bnd(0, 0); expect_acc("R1", 0, 0, 0);
    cur_mask = 4; idle(1);
    bnd(0, 0); expect_acc("R1", 1, 0, 3);
    setr(0, 1, 7, 0); cur_mask = 7; idle(1);
    bnd(0, 0); expect_acc("R1", 0, 0, 0);
    setr(0, 0, 0, 0); idle(1);

    tag = "R3"; // no strobe without boundary, one-cycle pulse
    setr(1, 1, 2, 0); idle(3);
    chk("R3", int'(acc_valid), 0, "no boundary");
    bnd(0, 0); expect_acc("R3", 1, 1, 2);
    tick(); chk("R3", int'(acc_valid), 0, "pulse length");
    setr(1, 0, 0, 0);

    tag = "R2"; // lowest level, then lowest index
    setr(0, 1, 4, 0); setr(5, 1, 1, 0); setr(2, 1, 1, 0); idle(1);
    bnd(0, 0); expect_acc("R2", 1, 2, 1);
    setr(2, 0, 0, 0); idle(1);
    bnd(0, 0); expect_acc("R2", 1, 5, 1);
    setr(0, 0, 0, 0); setr(5, 0, 0, 0); idle(1);

    tag = "R5";
    int_enable = 0; setr(3, 1, 0, 0); idle(1);
    bnd(0, 0); expect_acc("R5", 0, 0, 0);
    int_enable = 1; setr(3, 0, 0, 0); idle(1);

    tag = "R4"; // preemption and holding during a handler
    cur_mask = 5; setr(6, 1, 5, 0); setr(7, 1, 2, 0); idle(1);
    bnd(0, 0); expect_acc("R4", 1, 7, 2);
    cur_mask = 2; idle(1);
    bnd(0, 0); expect_acc("R4", 0, 0, 0);
    setr(7, 0, 0, 0); cur_mask = 5; idle(1);
    bnd(0, 0); expect_acc("R4", 0, 0, 0);
    cur_mask = 7; idle(1);
    bnd(0, 0); expect_acc("R4", 1, 6, 5);
    setr(6, 0, 0, 0); idle(1);

    tag = "R6"; // io access with a pending request in the same boundary
    setr(0, 1, 2, 0); bnd(1, 0); expect_acc("R6", 0, 0, 0);
    idle(2); bnd(0, 0); expect_acc("R6", 0, 0, 0);
    idle(2); bnd(0, 0); expect_acc("R6", 1, 0, 2);
    idle(1);

    tag = "R7";
    bnd(0, 1); expect_acc("R7", 0, 0, 0);
    idle(1); bnd(0, 0); expect_acc("R7", 0, 0, 0);
    idle(1); bnd(0, 0); expect_acc("R7", 1, 0, 2);
    setr(0, 0, 0, 0); idle(1);

    tag = "R11";
    setr(3, 1, 1, 1); idle(1);
    bnd(0, 0); expect_acc("R11", 1, 3, 1);
    chk("R11", int'(acc_svc), 1, "acc_svc");
    setr(3, 0, 0, 0);

    tag = "R8"; // busy blocks all; done in the same cycle as a boundary
    setr(1, 1, 0, 0); setr(4, 1, 2, 1); idle(1);
    bnd(0, 0); expect_acc("R8", 0, 0, 0);
    svc_done = 1; bnd(0, 0); svc_done = 0;
    expect_acc("R8", 0, 0, 0);
    idle(1); bnd(0, 0); expect_acc("R8", 1, 1, 0);
    setr(1, 0, 0, 0); setr(4, 0, 0, 0); idle(1);

    tag = "R9"; // flag left set triggers again
    setr(4, 1, 3, 0); bnd(0, 0); expect_acc("R9", 1, 4, 3);
    cur_mask = 3; idle(1);
    bnd(0, 0); expect_acc("R9", 0, 0, 0);
    cur_mask = 7; idle(1);
    bnd(0, 0); expect_acc("R9", 1, 4, 3);
    setr(4, 0, 0, 0);

    tag = "R2"; // mixed traffic with back-to-back boundaries
    for (int k = 0; k < 40; k++) begin
      setr(k % N, 1, (k * 5) % 8, 0);
      if (k % 3 == 0) setr((k + 3) % N, 0, 0, 0);
      cur_mask = LW'(7 - (k % 4));
      instr_done = (k % 2 == 0);
      instr_io_access = (k % 7 == 0);
      tick();
    end
    instr_done = 0; instr_io_access = 0;
    idle(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule